// File: doc/BRIEF.md
# Nine-Line Programmable I/O Port with Change-of-State Interrupt

This block is a small general-purpose I/O port of nine lines. Each line is set as an input or an output through a direction register. The port also has an output-value register, an interrupt-enable register and a pending-event register. Software uses a simple synchronous register bus for all four registers. A read returns data one cycle after the access cycle.

Every input line first passes through a two-stage synchronizer. The block compares the synchronized level with its value one clock earlier. A change in either direction on a line that is both enabled and configured as an input sets that line's pending bit. The single interrupt output is high whenever any pending bit is set.

Software finds the cause of an interrupt by reading the pending register. That read returns the bits and clears all of them in the same access. An event that arrives in the cycle of that read is kept for the next read, so no event is lost.

Top module: `gpio_change_port`

## Requirements
- R1: After reset the direction, interrupt-enable and pending registers read as zero, pinOe is all zero and irq is low.
- R2: Register address 0 is direction. Bit n set to 1 makes line n an output (pinOe[n]=1). Bit n set to 0 makes line n an input.
- R3: A write to address 1 sets pinOut. A read of address 1 returns, per bit, the synchronized pin level for input lines and the written value for output lines.
- R4: A read access (busSel=1, busWrite=0) presents its data on busRdata after the clock edge that samples the access, and the data holds until the next read.
- R5: A low-to-high change on an input line whose enable bit (address 2) is set sets that line's pending bit and raises irq on the third clock edge after the change.
- R6: A high-to-low change on such a line sets its pending bit in the same way as a rising change.
- R7: A change on a line that is configured as an output, or whose enable bit is clear, never sets a pending bit.
- R8: A read of address 3 returns the pending bits and clears all nine of them. irq goes low when no bit remains.
- R9: If a change is detected in the same cycle as a pending-register read, the read returns the earlier bits and the new bit stays set.
- R10: Pending bits and irq stay set until a pending-register read. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register select: 0 direction, 1 data, 2 enable, 3 pending |
| busWdata | input | 9 | Write data |
| busRdata | output | 9 | Registered read data |
| pinIn | input | 9 | Pad input levels (asynchronous) |
| pinOut | output | 9 | Output values to pads |
| pinOe | output | 9 | Output enable per line |
| irq | output | 1 | Shared port interrupt |

## Verification
The assertions assume that pinIn reaches the block only through the synchronizer. Every pending-bit set is therefore traced back to a detected change in the previous cycle. They also assume that a bus access lasts exactly one cycle, so each read strobe matches one registered read result. The stimulus changes pins only on the falling clock edge and holds each level for several cycles. It issues single-cycle accesses, and it places one pin change so that the detected change lands exactly on a pending-register read.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_DIR  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_EN   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_PEND = 2'd3;

  typedef struct packed {
    logic wrDir;
    logic wrData;
    logic wrEn;
    logic rdDir;
    logic rdData;
    logic rdEn;
    logic rdPend;
  } strobe_t;
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);
  logic wrAcc;
  logic rdAcc;

  assign wrAcc = busSel & busWrite;
  assign rdAcc = busSel & ~busWrite;

  always_comb begin
    strb        = '0;
    strb.wrDir  = wrAcc & (busAddr == ADDR_DIR);
    strb.wrData = wrAcc & (busAddr == ADDR_DATA);
    strb.wrEn   = wrAcc & (busAddr == ADDR_EN);
    // a write to the pending address decodes to nothing
    strb.rdDir  = rdAcc & (busAddr == ADDR_DIR);
    strb.rdData = rdAcc & (busAddr == ADDR_DATA);
    strb.rdEn   = rdAcc & (busAddr == ADDR_EN);
    strb.rdPend = rdAcc & (busAddr == ADDR_PEND);
  end
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int NUM_LINES = 9,
  parameter int STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] asyncIn,
  output logic [NUM_LINES-1:0] syncOut
);
  logic [STAGES-1:0][NUM_LINES-1:0] stageQ;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int NUM_LINES = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [NUM_LINES-1:0] wdata,
  input  logic [NUM_LINES-1:0] syncPins,
  output logic [NUM_LINES-1:0] rdata,
  output logic [NUM_LINES-1:0] pinOut,
  output logic [NUM_LINES-1:0] dirQ,
  output logic [NUM_LINES-1:0] enQ,
  output logic [NUM_LINES-1:0] pendQ,
  output logic [NUM_LINES-1:0] chgMask
);
  logic [NUM_LINES-1:0] outQ;
  logic [NUM_LINES-1:0] prevQ;
  logic [NUM_LINES-1:0] pendNext;
  logic [NUM_LINES-1:0] dataView;
  logic [NUM_LINES-1:0] rdMux;
  logic                 rdAny;

  // change detect on eligible lines only
  assign chgMask  = (syncPins ^ prevQ) & enQ & ~dirQ;
  assign pendNext = (strb.rdPend ? '0 : pendQ) | chgMask;
  assign dataView = (syncPins & ~dirQ) | (outQ & dirQ);
  assign rdAny    = strb.rdDir | strb.rdData | strb.rdEn | strb.rdPend;

  always_comb begin
    rdMux = '0;
    if (strb.rdDir)  rdMux = dirQ;
    if (strb.rdData) rdMux = dataView;
    if (strb.rdEn)   rdMux = enQ;
    if (strb.rdPend) rdMux = pendQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ  <= '0;
      outQ  <= '0;
      enQ   <= '0;
      pendQ <= '0;
      prevQ <= '0;
      rdata <= '0;
    end else begin
      prevQ <= syncPins;
      pendQ <= pendNext;
      if (strb.wrDir)  dirQ <= wdata;
      if (strb.wrData) outQ <= wdata;
      if (strb.wrEn)   enQ  <= wdata;
      if (rdAny)       rdata <= rdMux;
    end
  end

  assign pinOut = outQ;
endmodule

// File: rtl/gpio_change_port.sv
module gpio_change_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_LINES   = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [NUM_LINES-1:0] busWdata,
  output logic [NUM_LINES-1:0] busRdata,
  input  logic [NUM_LINES-1:0] pinIn,
  output logic [NUM_LINES-1:0] pinOut,
  output logic [NUM_LINES-1:0] pinOe,
  output logic                 irq
);
  strobe_t              strb;
  logic [NUM_LINES-1:0] syncPins;
  logic [NUM_LINES-1:0] dirQ;
  logic [NUM_LINES-1:0] enQ;
  logic [NUM_LINES-1:0] pendQ;
  logic [NUM_LINES-1:0] chgMask;

  gpio_port_ctrl u_ctrl (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .strb    (strb)
  );

  gpio_port_sync #(.NUM_LINES(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(pinIn),
    .syncOut(syncPins)
  );

  gpio_port_dp #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wdata   (busWdata),
    .syncPins(syncPins),
    .rdata   (busRdata),
    .pinOut  (pinOut),
    .dirQ    (dirQ),
    .enQ     (enQ),
    .pendQ   (pendQ),
    .chgMask (chgMask)
  );

  assign pinOe = dirQ;
  assign irq   = |pendQ;
endmodule

// File: rtl/gpio_change_port_chk.sv
module gpio_change_port_chk #(
  parameter int NUM_LINES = 9
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 rdPend,
  input logic [NUM_LINES-1:0] dirQ,
  input logic [NUM_LINES-1:0] enQ,
  input logic [NUM_LINES-1:0] pendQ,
  input logic [NUM_LINES-1:0] chgMask,
  input logic [NUM_LINES-1:0] busRdata,
  input logic                 irq
);
  // R8
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdPend && chgMask == '0) |=> pendQ == '0);

  // R10
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdPend |=> (pendQ & $past(pendQ)) == $past(pendQ));

  // R7
  pend_eligible_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (pendQ & ~$past(pendQ) & ($past(dirQ) | ~$past(enQ))) == '0);

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(chgMask) != '0);

  // R4
  pend_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdPend |=> busRdata == $past(pendQ));
endmodule

bind gpio_change_port gpio_change_port_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .rdPend  (strb.rdPend),
  .dirQ    (dirQ),
  .enQ     (enQ),
  .pendQ   (pendQ),
  .chgMask (chgMask),
  .busRdata(busRdata),
  .irq     (irq)
);

// File: tb/gpio_change_port_bench.sv
module gpio_change_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 9;

  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_RD  = 2'd1;
  localparam logic [1:0] OP_PIN = 2'd2;

  // {op, addr, data, expected, requirement number}
  localparam int NVEC = 22;
  localparam logic [25:0] VEC [NVEC] = '{
    {OP_WR,  2'd0, 9'h0F0, 9'h000, 4'd2},  // R2 lines 4..7 out
    {OP_RD,  2'd0, 9'h000, 9'h0F0, 4'd2},  // R2
    {OP_PIN, 2'd0, 9'h003, 9'h000, 4'd3},
    {OP_WR,  2'd1, 9'h1A5, 9'h000, 4'd3},
    {OP_RD,  2'd1, 9'h000, 9'h0A3, 4'd3},  // R3 mixed view
    {OP_WR,  2'd2, 9'h1FF, 9'h000, 4'd5},
    {OP_RD,  2'd2, 9'h000, 9'h1FF, 4'd4},  // R4
    {OP_PIN, 2'd0, 9'h103, 9'h000, 4'd5},  // line 8 rises
    {OP_RD,  2'd3, 9'h000, 9'h100, 4'd5},  // R5
    {OP_RD,  2'd3, 9'h000, 9'h000, 4'd8},  // R8 cleared
    {OP_PIN, 2'd0, 9'h1F3, 9'h000, 4'd7},  // outputs toggle
    {OP_RD,  2'd3, 9'h000, 9'h000, 4'd7},  // R7
    {OP_PIN, 2'd0, 9'h1F2, 9'h000, 4'd6},  // line 0 falls
    {OP_RD,  2'd3, 9'h000, 9'h001, 4'd6},  // R6
    {OP_RD,  2'd3, 9'h000, 9'h000, 4'd8},  // R8
    {OP_WR,  2'd2, 9'h0FE, 9'h000, 4'd7},
    {OP_PIN, 2'd0, 9'h1F3, 9'h000, 4'd7},  // line 0 rises, disabled
    {OP_RD,  2'd3, 9'h000, 9'h000, 4'd7},  // R7
    {OP_WR,  2'd3, 9'h1FF, 9'h000, 4'd10},
    {OP_RD,  2'd3, 9'h000, 9'h000, 4'd10}, // R10 write ignored
    {OP_RD,  2'd2, 9'h000, 9'h0FE, 4'd4},  // R4
    {OP_RD,  2'd1, 9'h000, 9'h1A3, 4'd3}   // R3 line 8 input high now
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busSel = 1'b0;
  logic         busWrite = 1'b0;
  logic [1:0]   busAddr = '0;
  logic [N-1:0] busWdata = '0;
  logic [N-1:0] busRdata;
  logic [N-1:0] pinIn = '0;
  logic [N-1:0] pinOut;
  logic [N-1:0] pinOe;
  logic         irq;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_change_port u_gpio_change_port (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic doRead(input logic [1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
    d = busRdata;
  endtask

  task automatic setPins(input logic [N-1:0] v);
    @(negedge clk);
    pinIn = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pinOe", pinOe, '0);
    check("R1 irq", {8'h0, irq}, '0);
    doRead(2'd0, rd); check("R1 dir", rd, '0);
    doRead(2'd2, rd); check("R1 enable", rd, '0);
    doRead(2'd3, rd); check("R1 pending", rd, '0);

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]   op;
      logic [1:0]   a;
      logic [N-1:0] d;
      logic [N-1:0] e;
      logic [3:0]   r;
      {op, a, d, e, r} = VEC[i];
      case (op)
        OP_WR:  doWrite(a, d);
        OP_RD: begin
          doRead(a, rd);
          check($sformatf("R%0d vector %0d", r, i), rd, e);
        end
        default: setPins(d);
      endcase
    end

    // R2 R3 direction and output values at the pins
    check("R2 pinOe", pinOe, 9'h0F0);
    check("R3 pinOut", pinOut, 9'h1A5);

    // R10 irq stays up until a pending read; writes to address 3 ignored
    setPins(9'h1F1);
    check("R5 irq raised", {8'h0, irq}, 9'h001);
    repeat (10) @(negedge clk);
    doWrite(2'd3, 9'h000);
    check("R10 irq held", {8'h0, irq}, 9'h001);
    doRead(2'd3, rd); check("R8 pending value", rd, 9'h002);
    check("R8 irq cleared", {8'h0, irq}, 9'h000);

    // R5 exact latency: irq rises on the third edge after a change
    @(negedge clk); pinIn = 9'h1F5;
    @(negedge clk); check("R5 latency edge1", {8'h0, irq}, 9'h000);
    @(negedge clk); check("R5 latency edge2", {8'h0, irq}, 9'h000);
    @(negedge clk); check("R5 latency edge3", {8'h0, irq}, 9'h001);

    // R9 change detected in the cycle of a pending read
    @(negedge clk); pinIn = 9'h1FD;
    @(negedge clk);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = 2'd3;
    @(negedge clk);
    busSel = 1'b0;
    check("R9 read returns earlier bits", busRdata, 9'h004);
    check("R9 irq kept", {8'h0, irq}, 9'h001);
    doRead(2'd3, rd); check("R9 new bit kept", rd, 9'h008);

    // R1 reset in mid operation
    doWrite(2'd0, 9'h1FF);
    setPins(9'h0FD);
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 pinOe after reset", pinOe, '0);
    doRead(2'd0, rd); check("R1 dir after reset", rd, '0);
    doRead(2'd2, rd); check("R1 enable after reset", rd, '0);
    repeat (4) @(negedge clk);
    doRead(2'd3, rd); check("R1 pending after reset", rd, '0);
    check("R1 irq after reset", {8'h0, irq}, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule